// File: doc/BRIEF.md
# Block-Level Flash Page Mapper

This block translates logical sector numbers into physical flash page locations using a coarse, per-block mapping. The low three bits of a logical address give the page slot inside an eight-page block. The remaining upper bits name a virtual block. Each virtual block may own a home block, where page slot k holds logical page k. It may also own an overflow block, which collects rewrites in arrival order. Because flash pages cannot be overwritten until their block is erased, a second write to a home slot is placed in the next unused overflow page, and that page is tagged with its slot number.

The requester presents one operation per request: a write or a read, with a logical address. One cycle later the block answers with a status, a physical block number and a page number. When a write needs a fresh block, it takes the one offered on the allocation input in the same cycle as the request and pulses `alloc_take`. A read returns the newest copy of the page. The block finds it by scanning the overflow block from its most recently filled page downward, and falls back to the home slot if no overflow page matches.

Top module: `flash_blkmap`

## Requirements
- R1: Logical address bits [2:0] select the page slot and the upper bits select the virtual block (address 1011 maps to virtual block 126, slot 3).
- R2: A write to a virtual block with no home block, while `alloc_ok` is 1, adopts `alloc_blk` as the home block. It pulses `alloc_take` in the request cycle and answers with status OK (0), that block, and page = slot.
- R3: A write whose home slot is still unused answers with status OK, the home block and page = slot, and does not take a block.
- R4: A write to an already used home slot, when no overflow block exists, adopts `alloc_blk` as the overflow block (with `alloc_take`). It answers with status OK and page 0.
- R5: Further rewrites fill the overflow block strictly in page order 0, 1, …, 7, whatever their slots.
- R6: A rewrite that finds all 8 overflow pages used answers with status MERGE (2) and changes no state.
- R7: A read answers with status OK and the highest-numbered overflow page tagged with the requested slot. If no overflow page carries that tag, it answers with the home block and slot, provided that slot was written.
- R8: A read of a never-written slot or of an unmapped virtual block answers with status MISS (1) and changes no state.
- R9: A write that needs a new block while `alloc_ok` is 0 answers with status NOBLK (3), does not pulse `alloc_take`, and changes no state.
- R10: `rsp_valid` is 1 exactly in the cycle after an accepted request (`req_valid` high at a clock edge).
- R11: After reset every virtual block is unmapped and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_lba | input | LBA_W | Logical sector address |
| alloc_ok | input | 1 | A free block is offered |
| alloc_blk | input | PBA_W | Offered free block number |
| alloc_take | output | 1 | Offered block consumed this cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_status | output | 2 | 0 OK, 1 MISS, 2 MERGE, 3 NOBLK |
| rsp_blk | output | PBA_W | Physical block of the answer |
| rsp_page | output | 3 | Physical page of the answer |

## Verification
The hardest state to reach from the ports is a full overflow block whose tags mix several slots with repeats. In that state a read must select the newest of several matching pages, and a rewrite must be refused without disturbing anything. Directed sequences fill one virtual block's overflow with repeated rewrites of one slot and then try once more. Random traffic is confined to four virtual blocks and all eight slots, so that overflow blocks fill quickly with interleaved tags, and `alloc_ok` is withheld at times to produce refusals.

// File: rtl/flash_blkmap.sv
module flash_blkmap #(
  parameter int LBA_W = 10,
  parameter int PBA_W = 8,
  parameter int PPB   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic [LBA_W-1:0] req_lba,
  input  logic             alloc_ok,
  input  logic [PBA_W-1:0] alloc_blk,
  output logic             alloc_take,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [PBA_W-1:0] rsp_blk,
  output logic [$clog2(PPB)-1:0] rsp_page
);
  localparam int PG_W = $clog2(PPB);
  localparam int VB_W = LBA_W - PG_W;
  localparam int NVB  = 1 << VB_W;
  localparam int FW   = $clog2(PPB + 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_MISS = 2'd1, ST_MERGE = 2'd2, ST_NOBLK = 2'd3;

  typedef enum logic [2:0] {A_NONE, A_NEWPRIM, A_PRIM, A_NEWREPL, A_REPL} act_t;

  logic             mapped_q   [NVB];
  logic             has_repl_q [NVB];
  logic [PPB-1:0]   pused_q    [NVB];
  logic [FW-1:0]    fill_q     [NVB];
  logic [PBA_W-1:0] prim_q     [NVB];
  logic [PBA_W-1:0] repl_q     [NVB];
  logic [PG_W-1:0]  tag_q      [NVB][PPB];

  wire [VB_W-1:0] vb  = req_lba[LBA_W-1:PG_W];
  wire [PG_W-1:0] off = req_lba[PG_W-1:0];
  wire [FW-1:0]   cur_fill  = fill_q[vb];
  wire            repl_full = (cur_fill == FW'(PPB));

  logic            hit;
  logic [PG_W-1:0] hit_pg;
  always_comb begin
    hit = 1'b0;
    hit_pg = '0;
    for (int i = 0; i < PPB; i++)
      if (FW'(i) < cur_fill && tag_q[vb][i] == off) begin
        hit = 1'b1;
        hit_pg = PG_W'(i);
      end
  end

  act_t             act;
  logic [1:0]       st;
  logic [PBA_W-1:0] o_blk;
  logic [PG_W-1:0]  o_pg;
  always_comb begin
    act = A_NONE;
    st = ST_MISS;
    o_blk = '0;
    o_pg = '0;
    if (req_wr) begin
      if (!mapped_q[vb]) begin
        if (alloc_ok) begin act = A_NEWPRIM; st = ST_OK; o_blk = alloc_blk; o_pg = off; end
        else st = ST_NOBLK;
      end else if (!pused_q[vb][off]) begin
        act = A_PRIM; st = ST_OK; o_blk = prim_q[vb]; o_pg = off;
      end else if (!has_repl_q[vb]) begin
        if (alloc_ok) begin act = A_NEWREPL; st = ST_OK; o_blk = alloc_blk; o_pg = '0; end
        else st = ST_NOBLK;
      end else if (repl_full) begin
        st = ST_MERGE;
      end else begin
        act = A_REPL; st = ST_OK; o_blk = repl_q[vb]; o_pg = cur_fill[PG_W-1:0];
      end
    end else if (mapped_q[vb]) begin
      if (hit) begin
        st = ST_OK; o_blk = repl_q[vb]; o_pg = hit_pg;
      end else if (pused_q[vb][off]) begin
        st = ST_OK; o_blk = prim_q[vb]; o_pg = off;
      end
    end
  end

  assign alloc_take = req_valid && (act == A_NEWPRIM || act == A_NEWREPL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NVB; v++) begin
        mapped_q[v]   <= 1'b0;
        has_repl_q[v] <= 1'b0;
        pused_q[v]    <= '0;
        fill_q[v]     <= '0;
      end
    end else if (req_valid) begin
      case (act)
        A_NEWPRIM: begin mapped_q[vb] <= 1'b1; pused_q[vb][off] <= 1'b1; end
        A_PRIM:    pused_q[vb][off] <= 1'b1;
        A_NEWREPL: begin has_repl_q[vb] <= 1'b1; fill_q[vb] <= FW'(1); end
        A_REPL:    fill_q[vb] <= cur_fill + FW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      case (act)
        A_NEWPRIM: prim_q[vb] <= alloc_blk;
        A_NEWREPL: begin repl_q[vb] <= alloc_blk; tag_q[vb][0] <= off; end
        A_REPL:    tag_q[vb][cur_fill[PG_W-1:0]] <= off;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_blk    <= '0;
      rsp_page   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= st;
        rsp_blk    <= o_blk;
        rsp_page   <= o_pg;
      end
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R10
  AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(req_valid)); // R10
  AST_TAKE_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n) alloc_take |-> alloc_ok && req_wr); // R9
  AST_MISS_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && rsp_status == ST_MISS |-> !$past(req_wr)); // R8
  AST_MERGE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && rsp_status == ST_MERGE |-> $past(req_wr)); // R6
  AST_NOBLK_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && rsp_status == ST_NOBLK |-> !$past(alloc_ok)); // R9
endmodule

// File: tb/flash_blkmap_bench.sv
`timescale 1ns/1ps
module flash_blkmap_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, alloc_ok = 1'b0;
  logic [9:0] req_lba = '0;
  logic [7:0] alloc_blk = '0;
  logic alloc_take, rsp_valid;
  logic [1:0] rsp_status;
  logic [7:0] rsp_blk;
  logic [2:0] rsp_page;

  flash_blkmap u_flash_blkmap (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_lba(req_lba), .alloc_ok(alloc_ok), .alloc_blk(alloc_blk), .alloc_take(alloc_take),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_blk(rsp_blk), .rsp_page(rsp_page));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  bit m_map [128], m_hr [128];
  int m_prim [128], m_repl [128], m_fill [128];
  bit [7:0] m_pu [128];
  int m_tag [128][8];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input int lba, input bit aok, input int ablk);
    int vb = lba >> 3, off = lba & 7;
    int est = 1, eblk = 0, epg = 0, act = 0, hpg = -1;
    bit etake = 0;
    string tag;
    if (wr) begin
      if (!m_map[vb]) begin if (aok) begin act = 1; est = 0; eblk = ablk; epg = off; end else est = 3; end
      else if (!m_pu[vb][off]) begin act = 2; est = 0; eblk = m_prim[vb]; epg = off; end
      else if (!m_hr[vb]) begin if (aok) begin act = 3; est = 0; eblk = ablk; epg = 0; end else est = 3; end
      else if (m_fill[vb] == 8) est = 2;
      else begin act = 4; est = 0; eblk = m_repl[vb]; epg = m_fill[vb]; end
    end else if (m_map[vb]) begin
      for (int i = 0; i < m_fill[vb]; i++) if (m_tag[vb][i] == off) hpg = i;
      if (hpg >= 0) begin est = 0; eblk = m_repl[vb]; epg = hpg; end
      else if (m_pu[vb][off]) begin est = 0; eblk = m_prim[vb]; epg = off; end
    end
    etake = (act == 1 || act == 3);
    case (act)
      1: tag = "R2"; 2: tag = "R3"; 3: tag = "R4"; 4: tag = "R5";
      default: tag = (est == 2) ? "R6" : (est == 3) ? "R9" : (est == 1) ? "R8" : "R7";
    endcase
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "idle rsp_valid", int'(rsp_valid), 0);
    req_valid = 1'b1; req_wr = wr; req_lba = 10'(lba); alloc_ok = aok; alloc_blk = 8'(ablk);
    #1;
    chk(alloc_take == etake, tag, "alloc_take", int'(alloc_take), int'(etake));
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R10", "rsp_valid", int'(rsp_valid), 1);
    chk(int'(rsp_status) == est, tag, "status", int'(rsp_status), est);
    if (est == 0) begin
      chk(int'(rsp_blk) == eblk, tag, "block", int'(rsp_blk), eblk);
      chk(int'(rsp_page) == epg, tag, "page", int'(rsp_page), epg);
    end
    req_valid = 1'b0;
    case (act)
      1: begin m_map[vb] = 1; m_prim[vb] = ablk; m_pu[vb][off] = 1; end
      2: m_pu[vb][off] = 1;
      3: begin m_hr[vb] = 1; m_repl[vb] = ablk; m_tag[vb][0] = off; m_fill[vb] = 1; end
      4: begin m_tag[vb][m_fill[vb]] = off; m_fill[vb]++; end
      default: ;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", int'(rsp_valid), 0);
    chk(alloc_take == 1'b0, "R11", "reset alloc_take", int'(alloc_take), 0);
    rst_n = 1'b1;
    // R11 and R8: nothing mapped after reset
    do_req(0, 1011, 1, 5);
    // R9: refused without offer
    do_req(1, 1011, 0, 5);
    do_req(1, 1011, 1, 9);
    // R1: 1011 -> virtual block 126 slot 3
    chk(int'(rsp_page) == 3, "R1", "slot of 1011", int'(rsp_page), 3);
    do_req(0, 1010, 1, 40);
    do_req(1, 1010, 1, 40);
    do_req(1, 1011, 0, 23);
    do_req(1, 1011, 1, 23);
    do_req(0, 1011, 1, 50);
    do_req(0, 1010, 1, 50);
    for (int k = 0; k < 3; k++) do_req(1, 1011, 1, 60);
    do_req(1, 1010, 1, 60);
    for (int k = 0; k < 3; k++) do_req(1, 1011, 1, 60);
    do_req(0, 1010, 1, 60);
    do_req(0, 1011, 1, 60);
    do_req(1, 1008, 1, 60);
    // R6: overflow full
    do_req(1, 1010, 1, 61);
    do_req(1, 1011, 1, 61);
    do_req(0, 1011, 1, 61);
    do_req(0, 1009, 1, 61);
    for (int n = 0; n < 600; n++) begin
      int lba = int'(($urandom % 4) * 8 + ($urandom % 8));
      if ($urandom % 8 == 0) lba = int'($urandom % 1024);
      do_req(bit'($urandom % 2), lba, ($urandom % 8) != 0, int'($urandom % 256));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule